// File: doc/BRIEF.md
# Serial-Grant Bus Arbiter

This block decides which of several bus masters may use a shared bus. It uses one grant that passes from device to device instead of one private grant wire per master. The requests from all masters are ORed onto one shared request line. The releases from all masters are ORed onto one shared release line. When the bus is free and the shared request is high, the central controller drives a single grant into the chain at device 0. Each device slice keeps that grant if it is requesting. A slice that is not requesting passes the grant on unchanged to the next slice. Priority therefore comes only from position in the chain: device 0 ranks highest and device N-1 ranks lowest.

The winning slice latches ownership and shows it on its granted output. It keeps the bus until a release pulse arrives, and requests that change in the meantime have no effect. After a release the controller keeps the chain grant low for one extra cycle before it arbitrates again, so ownership can pass to a new winner. The scheme makes no promise of fairness. A high-priority master that keeps requesting wins every arbitration and can shut out the masters below it for as long as it requests.

Top module: `daisy_grant_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bit of `grantVec` is 0, whatever the requests are.
- R2: When the bus is free and at least one bit of `reqVec` is 1 before a rising edge, `grantVec` becomes one-hot after that edge. The bit that is set is the lowest-indexed requester, since index 0 has the highest priority.
- R3: A device gets the grant only if its own `reqVec` bit was 1 in the cycle of arbitration. A non-requesting device passes the grant on and is never granted.
- R4: While the bus is owned and no release is seen, `grantVec` stays the same, even when any `reqVec` bit changes, including the bit of a higher-priority device.
- R5: The shared release is the OR of `relVec`. If it is 1 before an edge while the bus is owned, `grantVec` is all zero after that edge.
- R6: After a release, `grantVec` stays all zero for one more cycle. A new grant appears no earlier than two edges after the edge that took the release.
- R7: At most one bit of `grantVec` is ever 1. Exactly one bit is 1 for as long as the bus is owned.
- R8: A `relVec` pulse while the bus is free is ignored. A later request is granted one edge after it is seen, as R2 states.
- R9: If the highest-ranked requester keeps requesting, it wins every arbitration that follows a release, and a lower requester waits without limit.
- R10: With every bit of `reqVec` at 0 and the bus free, `grantVec` stays all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqVec | input | NUM_MASTERS | Request from each device; bit 0 ranks highest |
| relVec | input | NUM_MASTERS | Release pulse from each device; the bits are ORed into one shared release |
| grantVec | output | NUM_MASTERS | Granted flag per device, registered |

## Verification
A fault in the grant chain shows up as the wrong winner, or as two set bits in `grantVec`, on the first edge after a request arrives while the bus is free. A controller stuck in the wrong state shows up within one or two cycles of a release. In that case the grant is either held through the release, or it comes back without the one-cycle idle gap. An owner register that takes a new value while the bus is owned shows up as a change in `grantVec` on the first edge after any request change.

// File: rtl/dgarb_pkg.sv
package dgarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OWNED = 2'd1,
    ST_GAP   = 2'd2
  } arbState_t;

  typedef struct packed {
    logic chainGrant;  // grant injected at head of chain
    logic clearOwner;  // drop latched ownership
  } ctrlStrobes_t;
endpackage

// File: rtl/dgarb_slice.sv
module dgarb_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic grantIn,
  input  logic req,
  input  logic clearOwner,
  output logic grantOut,
  output logic owned
);
  logic takeGrant;

  // a requesting slice absorbs the grant, others forward it
  assign takeGrant = grantIn & req;
  assign grantOut  = grantIn & ~req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          owned <= 1'b0;
    else if (clearOwner) owned <= 1'b0;
    else if (takeGrant)  owned <= 1'b1;
  end

  p_take_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned) |-> $past(req));
endmodule

// File: rtl/dgarb_chain.sv
module dgarb_chain
  import dgarb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctrlStrobes_t           strobes,
  input  logic                   busOwned,
  input  logic [NUM_MASTERS-1:0] reqVec,
  output logic [NUM_MASTERS-1:0] ownerVec
);
  localparam int LINKS = NUM_MASTERS + 1;

  logic [LINKS-1:0] link;

  assign link[0] = strobes.chainGrant;

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_slice
    dgarb_slice slice_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .grantIn   (link[g]),
      .req       (reqVec[g]),
      .clearOwner(strobes.clearOwner),
      .grantOut  (link[g+1]),
      .owned     (ownerVec[g])
    );
  end

  p_onehot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ownerVec));

  p_owned_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busOwned |-> $onehot(ownerVec));

  p_free_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busOwned |-> (ownerVec == '0));
endmodule

// File: rtl/dgarb_ctrl.sv
module dgarb_ctrl
  import dgarb_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         anyReq,
  input  logic         anyRel,
  output ctrlStrobes_t strobes,
  output logic         busOwned
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes            = '0;
    unique case (state)
      ST_IDLE: begin
        strobes.chainGrant = anyReq;
        if (anyReq) stateNext = ST_OWNED;
      end
      ST_OWNED: begin
        if (anyRel) begin
          strobes.clearOwner = 1'b1;
          stateNext          = ST_GAP;
        end
      end
      ST_GAP:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busOwned = (state == ST_OWNED);

  p_idle_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && anyReq) |=> (state == ST_OWNED));

  p_gap_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWNED && anyRel) |=> (state == ST_GAP));

  p_gap_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> !strobes.chainGrant);

  p_stay_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !anyReq) |=> (state == ST_IDLE));
endmodule

// File: rtl/daisy_grant_arbiter.sv
module daisy_grant_arbiter
  import dgarb_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] reqVec,
  input  logic [NUM_MASTERS-1:0] relVec,
  output logic [NUM_MASTERS-1:0] grantVec
);
  ctrlStrobes_t strobes;
  logic         busOwned;
  logic         sharedReq;
  logic         sharedRel;

  // wired-OR shared lines
  assign sharedReq = |reqVec;
  assign sharedRel = |relVec;

  dgarb_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .anyReq  (sharedReq),
    .anyRel  (sharedRel),
    .strobes (strobes),
    .busOwned(busOwned)
  );

  dgarb_chain #(.NUM_MASTERS(NUM_MASTERS)) chain_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .busOwned(busOwned),
    .reqVec  (reqVec),
    .ownerVec(grantVec)
  );

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grantVec != '0) && !sharedRel) |=> $stable(grantVec));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grantVec != '0) && sharedRel) |=> (grantVec == '0));

  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|grantVec) |=> (grantVec == '0));

  p_winner_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grantVec) |-> (($past(reqVec) & grantVec) != '0));
endmodule

// File: tb/daisy_grant_arbiter_tb.sv
module daisy_grant_arbiter_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic [N-1:0] relVec = '0;
  logic [N-1:0] grantVec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  daisy_grant_arbiter #(.NUM_MASTERS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .relVec(relVec), .grantVec(grantVec)
  );

  // {req, rel, expected grant after the next edge}
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_0000_0000,  // R10 idle
    12'b0110_0000_0010,  // R2 lowest index wins
    12'b0111_0000_0010,  // R4 frozen despite higher req
    12'b0101_0010_0000,  // R5 release
    12'b0101_0000_0000,  // R6 gap
    12'b0101_0000_0001,  // R2 new winner
    12'b0100_0001_0000,  // R5 release
    12'b0100_0000_0000,  // R6 gap
    12'b0100_0000_0100,  // R3 passed over idle devices
    12'b0000_0100_0000,  // R5 release
    12'b0000_0000_0000,  // R6 gap
    12'b0000_1000_0000,  // R8 release while free ignored
    12'b1000_0000_1000,  // R8 lowest device granted next edge
    12'b1001_0000_1000   // R4 frozen
  };

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp || $countones(act) > 1) begin
      failures++;
      $display("FAIL %s grantVec=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] rl,
                      input logic [N-1:0] exp, input string tag);
    reqVec = rq;
    relVec = rl;
    @(negedge clk);
    check(tag, grantVec, exp);
  endtask

  initial begin
    // R1: requests during reset must not grant
    reqVec = '1;
    repeat (3) @(negedge clk);
    check("R1 in reset", grantVec, '0);
    reqVec = '0;
    rst_n  = 1'b1;
    @(negedge clk);
    check("R1 after reset", grantVec, '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0], $sformatf("vec%0d R2-R10 table", i));
    end

    // R9: device 0 keeps winning over device 3
    for (int k = 0; k < 3; k++) begin
      step(4'b1001, (k == 0) ? 4'b1000 : 4'b0001, 4'b0000, "R9 release");
      step(4'b1001, 4'b0000, 4'b0000, "R9 gap");
      step(4'b1001, 4'b0000, 4'b0001, "R9 high wins again");
    end

    // R5: release from a non-owner on the shared line still frees bus
    step(4'b1001, 4'b0100, 4'b0000, "R5 shared release");

    // R1: reset while owned
    step(4'b0000, 4'b0000, 4'b0000, "R6 gap");
    step(4'b0010, 4'b0000, 4'b0010, "R2 single requester");
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset while owned", grantVec, '0);
    rst_n = 1'b1;
    step(4'b0000, 4'b0000, 4'b0000, "R10 no request");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule